// File: doc/BRIEF.md
# Eight-Pin External Interrupt Pending Unit

This block watches a bank of GPIO input lines and turns chosen level or edge conditions on each line into latched pending flags. Every input is first brought into the clock domain through a synchroniser, then optionally passed through a noise filter, and finally compared against a per-pin trigger setting. A detected condition sets that pin's pending flag, whether or not the pin is masked. Software sees the flags through a small word-addressed register bus and clears them by writing ones.

A single interrupt request is raised while at least one pending flag belongs to an unmasked pin. Software uses the unit by picking a trigger code for each pin, clearing the mask bits of the pins it wants to hear from, and, in its handler, reading the pending register and writing back the bits it has serviced.

Top module: `eint_unit`

## Requirements
- R1: After reset every trigger field holds code 2, all mask bits are 1, all pending bits are 0, all filter-enable bits are 1, and the request output is low.
- R2: Word address 0 holds the trigger fields, pin n at bits [4n+2:4n], with bit 4n+3 and any bit above the last field reading 0; address 1 holds the mask bits, address 2 the pending bits and address 3 the filter-enable bits, with pin n at bit n in each.
- R3: Trigger code 2 detects a falling edge, code 3 a rising edge, and codes 4 to 7 detect both edges; an edge of the other direction leaves the pending bit at 0.
- R4: Code 0 detects a low level and code 1 a high level; while that level persists the pending bit is set again on every clock, so a clear has no lasting effect.
- R5: A detected condition sets the pending bit even when the pin's mask bit is 1.
- R6: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged.
- R7: When a detected condition and a clearing write hit the same pending bit in the same cycle, the bit ends up 1.
- R8: The request output is high exactly when some pin has its pending bit 1 and its mask bit 0; a mask bit of 1 blocks that pin.
- R9: With the filter enabled, an input change must hold for 4 consecutive clocks after synchronisation before detection sees it; a pulse of 3 clocks is ignored, and a held falling edge sets pending on the 7th rising clock edge after the input changes.
- R10: With the filter disabled for a pin, a 2-clock pulse is detected and a falling edge sets pending on the 4th rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Asynchronous GPIO input lines |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per clock it is high |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a hardware set and a software clear landing on the same pending bit in the same clock, since an edge event lasts one cycle deep behind the synchroniser and filter. The stimulus gets there through a level mode, where the condition is present on every clock, so any clearing write collides with a set. Filter timing is checked by changing a pin on a falling clock edge and reading pending after exactly six and seven rising edges, and glitch rejection by pulses one clock shorter than the filter window.

// File: rtl/eint_pkg.sv
package eint_pkg;
    localparam int TRIG_W     = 3;
    localparam int FIELD_W    = 4;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_TRIG = 2'd0,
        REG_MASK = 2'd1,
        REG_PEND = 2'd2,
        REG_FILT = 2'd3
    } reg_sel_e;

    localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_FALL = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_RISE = 3'd3;
endpackage

// File: rtl/eint_pin_cond.sv
module eint_pin_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic filt_en_i,
    output logic lvl_o,
    output logic prev_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   lvl;
        logic                   prev;
    } cond_t;

    cond_t st_d, st_q;
    logic  sync_out;

    assign sync_out = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = st_q.lvl;
        if (!filt_en_i) begin
            st_d.lvl = sync_out;
            st_d.cnt = '0;
        end else if (sync_out == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_W'(FILT_LEN - 1)) begin
            st_d.lvl = sync_out;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.lvl;
    assign prev_o = st_q.prev;

    AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_en_i && sync_out == st_q.lvl) |=> (st_q.lvl == $past(st_q.lvl))); // R9

    AST_BYPASS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !filt_en_i |=> (st_q.lvl == $past(sync_out))); // R10
endmodule

// File: rtl/eint_trig_dec.sv
module eint_trig_dec
    import eint_pkg::*;
(
    input  logic [TRIG_W-1:0] code_i,
    input  logic              lvl_i,
    input  logic              prev_i,
    output logic              evt_o
);
    always_comb begin
        case (code_i)
            TRIG_LOW:  evt_o = !lvl_i;
            TRIG_HIGH: evt_o = lvl_i;
            TRIG_FALL: evt_o = prev_i && !lvl_i;
            TRIG_RISE: evt_o = !prev_i && lvl_i;
            default:   evt_o = prev_i ^ lvl_i;
        endcase
    end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 32
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         we_i,
    input  logic [REG_ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [NUM_PINS-1:0]          evt_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic [NUM_PINS*TRIG_W-1:0]   trig_o,
    output logic [NUM_PINS-1:0]          mask_o,
    output logic [NUM_PINS-1:0]          pend_o,
    output logic [NUM_PINS-1:0]          filt_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0][TRIG_W-1:0] trig;
        logic [NUM_PINS-1:0]             mask;
        logic [NUM_PINS-1:0]             pend;
        logic [NUM_PINS-1:0]             filt;
    } regs_t;

    regs_t               rg_d, rg_q;
    logic [NUM_PINS-1:0] clr;
    logic                wr_pend;

    assign wr_pend = we_i && (addr_i == REG_PEND);
    assign clr     = wr_pend ? wdata_i[NUM_PINS-1:0] : '0;

    always_comb begin
        rg_d = rg_q;
        if (we_i) begin
            case (addr_i)
                REG_TRIG: for (int n = 0; n < NUM_PINS; n++)
                              rg_d.trig[n] = wdata_i[n*FIELD_W +: TRIG_W];
                REG_MASK: rg_d.mask = wdata_i[NUM_PINS-1:0];
                REG_FILT: rg_d.filt = wdata_i[NUM_PINS-1:0];
                default:  ;
            endcase
        end
        rg_d.pend = (rg_q.pend & ~clr) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int n = 0; n < NUM_PINS; n++) rg_q.trig[n] <= TRIG_FALL;
            rg_q.mask <= '1;
            rg_q.pend <= '0;
            rg_q.filt <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_TRIG: for (int n = 0; n < NUM_PINS; n++)
                          rdata_o[n*FIELD_W +: TRIG_W] = rg_q.trig[n];
            REG_MASK: rdata_o[NUM_PINS-1:0] = rg_q.mask;
            REG_PEND: rdata_o[NUM_PINS-1:0] = rg_q.pend;
            default:  rdata_o[NUM_PINS-1:0] = rg_q.filt;
        endcase
    end

    assign trig_o = rg_q.trig;
    assign mask_o = rg_q.mask;
    assign pend_o = rg_q.pend;
    assign filt_o = rg_q.filt;

    AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_pend |=> ((rg_q.pend & $past(rg_q.pend)) == $past(rg_q.pend))); // R6

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr & evt_i)) |=> ((rg_q.pend & $past(clr & evt_i)) == $past(clr & evt_i))); // R7

    AST_SET_BY_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((rg_q.pend & ~$past(rg_q.pend) & ~$past(evt_i)) == '0)); // R5
endmodule

// File: rtl/eint_unit.sv
module eint_unit
    import eint_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    input  logic                  bus_we_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  irq_o
);
    logic [NUM_PINS*TRIG_W-1:0] trig;
    logic [NUM_PINS-1:0]        mask, pend, filt, evt, lvl, prev;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        eint_pin_cond #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) cond_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .pin_i     (pins_i[n]),
            .filt_en_i (filt[n]),
            .lvl_o     (lvl[n]),
            .prev_o    (prev[n])
        );

        eint_trig_dec dec_i (
            .code_i (trig[n*TRIG_W +: TRIG_W]),
            .lvl_i  (lvl[n]),
            .prev_i (prev[n]),
            .evt_o  (evt[n])
        );
    end

    eint_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt),
        .rdata_o (bus_rdata_o),
        .trig_o  (trig),
        .mask_o  (mask),
        .pend_o  (pend),
        .filt_o  (filt)
    );

    assign irq_o = |(pend & ~mask);

    AST_IRQ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask) |-> !irq_o); // R8

    AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend == '0) |-> !irq_o); // R8
endmodule

// File: tb/eint_unit_tb.sv
module eint_unit_tb_top;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    eint_unit #(.NUM_PINS(NP)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pins_i      (pins),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef enum logic [1:0] {OP_WR, OP_PIN, OP_RD, OP_IRQ} op_e;
    typedef struct packed {
        op_e         op;
        logic [1:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,  2'd0, 32'h0, 32'h22222222, 8'd1},  // R1
        '{OP_RD,  2'd1, 32'h0, 32'h000000FF, 8'd1},  // R1
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd1},  // R1
        '{OP_RD,  2'd3, 32'h0, 32'h000000FF, 8'd1},  // R1
        '{OP_IRQ, 2'd0, 32'h0, 32'h0,        8'd1},  // R1
        '{OP_WR,  2'd1, 32'hFE, 32'h0,       8'd0},
        '{OP_PIN, 2'd0, 32'h01, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd3},  // R3 rise ignored in fall mode
        '{OP_PIN, 2'd0, 32'h00, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h01,       8'd3},  // R3 fall
        '{OP_IRQ, 2'd0, 32'h0, 32'h1,        8'd8},  // R8
        '{OP_WR,  2'd2, 32'h00, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h01,       8'd6},  // R6 zero write
        '{OP_WR,  2'd2, 32'h01, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd6},  // R6 one write
        '{OP_IRQ, 2'd0, 32'h0, 32'h0,        8'd8},  // R8
        '{OP_WR,  2'd0, 32'h22222232, 32'h0, 8'd0},
        '{OP_PIN, 2'd0, 32'h02, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h02,       8'd5},  // R5 masked pin pends
        '{OP_IRQ, 2'd0, 32'h0, 32'h0,        8'd8},  // R8 blocked
        '{OP_WR,  2'd1, 32'hFC, 32'h0,       8'd0},
        '{OP_IRQ, 2'd0, 32'h0, 32'h1,        8'd8},  // R8 unmasked
        '{OP_WR,  2'd2, 32'h02, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd6},  // R6
        '{OP_WR,  2'd0, 32'h22222532, 32'h0, 8'd0},
        '{OP_PIN, 2'd0, 32'h06, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h04,       8'd3},  // R3 both, rise
        '{OP_WR,  2'd2, 32'h04, 32'h0,       8'd0},
        '{OP_PIN, 2'd0, 32'h02, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h04,       8'd3},  // R3 both, fall
        '{OP_WR,  2'd2, 32'h04, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd6},  // R6
        '{OP_WR,  2'd0, 32'h22221532, 32'h0, 8'd0},
        '{OP_PIN, 2'd0, 32'h0A, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h08,       8'd4},  // R4 high level
        '{OP_WR,  2'd2, 32'h08, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h08,       8'd7},  // R7 set beats clear
        '{OP_PIN, 2'd0, 32'h02, 32'd10,      8'd0},
        '{OP_WR,  2'd2, 32'h08, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd4},  // R4 level gone
        '{OP_WR,  2'd0, 32'h22201532, 32'h0, 8'd0},
        '{OP_PIN, 2'd0, 32'h02, 32'd10,      8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h10,       8'd4},  // R4 low level
        '{OP_IRQ, 2'd0, 32'h0, 32'h0,        8'd8},  // R8 pin4 masked
        '{OP_PIN, 2'd0, 32'h12, 32'd10,      8'd0},
        '{OP_WR,  2'd2, 32'h10, 32'h0,       8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd4},  // R4
        '{OP_WR,  2'd0, 32'hFFFFFFFF, 32'h0, 8'd0},
        '{OP_RD,  2'd0, 32'h0, 32'h77777777, 8'd2},  // R2 field layout
        '{OP_WR,  2'd0, 32'h22222222, 32'h0, 8'd0},
        '{OP_RD,  2'd2, 32'h0, 32'h0,        8'd2}   // R2
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling clock edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input int req);
        addr = a; we = 1'b0;
        #1;
        check(rdata, e, req);
    endtask

    task automatic set_pins(input logic [7:0] v, input int cyc);
        pins = v;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR:   wr(VECS[i].a, VECS[i].d);
                OP_PIN:  set_pins(VECS[i].d[7:0], int'(VECS[i].e));
                OP_RD:   rd_chk(VECS[i].a, VECS[i].e, int'(VECS[i].req));
                default: check({31'b0, irq}, VECS[i].e, int'(VECS[i].req));
            endcase
        end

        // R9: 3-clock low pulse on pin5 with filter on is ignored
        set_pins(8'h32, 12);
        set_pins(8'h12, 3);
        set_pins(8'h32, 12);
        rd_chk(2'd2, 32'h0, 9);  // R9 glitch rejected

        // R9: filtered falling edge latency on pin6
        set_pins(8'h72, 12);
        set_pins(8'h32, 6);
        rd_chk(2'd2, 32'h0, 9);  // R9 not yet after 6 edges
        @(negedge clk);
        rd_chk(2'd2, 32'h40, 9); // R9 set on 7th edge
        wr(2'd2, 32'h40);

        // R10: filter off for pin5, short pulse passes
        wr(2'd3, 32'hDF);
        rd_chk(2'd3, 32'hDF, 10); // R10
        set_pins(8'h12, 2);
        set_pins(8'h32, 12);
        rd_chk(2'd2, 32'h20, 10); // R10 pulse seen
        wr(2'd2, 32'h20);
        rd_chk(2'd2, 32'h0, 10);  // R10
        set_pins(8'h12, 3);
        rd_chk(2'd2, 32'h0, 10);  // R10 not yet after 3 edges
        @(negedge clk);
        rd_chk(2'd2, 32'h20, 10); // R10 set on 4th edge

        // R1: reset mid-run returns all registers to defaults
        wr(2'd1, 32'h00);
        check({31'b0, irq}, 32'h1, 8); // R8
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd2, 32'h0, 1);         // R1
        rd_chk(2'd1, 32'hFF, 1);        // R1
        rd_chk(2'd3, 32'hFF, 1);        // R1
        rd_chk(2'd0, 32'h22222222, 1);  // R1
        check({31'b0, irq}, 32'h0, 1);  // R1

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule